// File: doc/BRIEF.md
# Idle and Power-Down Mode Controller

This block is the power-management register and sleep sequencer for a small 8-bit microcontroller core. Software writes a byte-wide control register over a simple special-function-register bus. One bit of that register puts the core into idle, where the CPU clock enable drops but the timer and interrupt domains keep running. Another bit puts it into power-down, where every clock enable drops. Two further bits are plain software flags. One bit chooses how an idle exit is handled.

While the core sleeps, the block watches its wake sources. Idle ends on any interrupt request: a pending request from the interrupt logic, any of the four external interrupt lines, or the ring-detect event. Power-down ends only on one of the four external interrupt lines or the ring-detect event. On exit, the block clears the sleep bit, restores the clock enables, and gives the core a one-cycle resume pulse. A companion output on that pulse tells the core whether to vector to the pending interrupt or to carry on from where it stopped.

The asynchronous active-low reset is synchronised internally before its release.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset, the control register at address 0x87 reads 0x00, both clock enables are high, and resume_pulse and vector_en are low.
- R2: A write to address 0x87 stores data bits 4..0: IDL is bit 0, PD is bit 1, the flags are bits 3 and 2, and IDLT is bit 4. Bits 7..5 always read 0. A read from any other address returns 0x00, and a write to any other address changes nothing.
- R3: The flag bits (2 and 3) and IDLT on their own leave both clock enables high and raise no resume pulse.
- R4: A write with IDL=1 and PD=0 enters idle. From the next cycle, cpu_clk_en is low and periph_clk_en is high.
- R5: A write with PD=1 enters power-down. From the next cycle, both clock enables are low. When IDL and PD are written as 1 together, power-down wins and the register reads back with PD=1 and IDL=0.
- R6: Idle is left when irq_pending, any ext_int_req line or ring_det is high at a clock edge.
- R7: Power-down is left only when an ext_int_req line or ring_det is high at a clock edge. irq_pending alone keeps the block powered down.
- R8: In the cycle after the wake is sampled, both clock enables are high, resume_pulse is high for exactly that one cycle, and the register reads back with IDL and PD cleared while the other bits are kept.
- R9: vector_en is high only together with resume_pulse. On an idle exit it equals the inverse of IDLT. On a power-down exit it is 1.
- R10: While in idle or power-down, bus writes to the control register are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sfr_addr | input | 8 | Register bus address |
| sfr_wr | input | 1 | Register bus write strobe |
| sfr_wdata | input | 8 | Register bus write data |
| sfr_rdata | output | 8 | Register bus read data (combinational) |
| ext_int_req | input | 4 | External interrupt requests, wake sources |
| ring_det | input | 1 | Ring-detect wake event |
| irq_pending | input | 1 | Any enabled interrupt pending (wakes idle only) |
| cpu_clk_en | output | 1 | Clock enable for the CPU core |
| periph_clk_en | output | 1 | Clock enable for the timer and interrupt domains |
| resume_pulse | output | 1 | One-cycle strobe on leaving a sleep mode |
| vector_en | output | 1 | With resume_pulse: take the pending interrupt |

## Verification
The hardest states to reach are the stimuli that must be ignored while the core is asleep: bus writes, and irq_pending while in power-down. A stuck or leaky controller looks the same as a correct one unless those stimuli are applied and the block is then observed still asleep. The bench sweeps all 32 combinations of the five live register bits, with varied upper bits. For each combination that sleeps, it writes 0x00, reads the register back, pulses irq_pending in power-down, and confirms that the clock enables have not moved. It then wakes the block through a wake source that rotates across the sweep, and checks the resume pulse, vector_en and the cleared register.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;
  typedef enum logic [1:0] {
    MODE_RUN   = 2'd0,
    MODE_IDLE  = 2'd1,
    MODE_PDOWN = 2'd2
  } pwr_mode_e;

  localparam int BIT_IDL  = 0;
  localparam int BIT_PD   = 1;
  localparam int BIT_GF0  = 2;
  localparam int BIT_GF1  = 3;
  localparam int BIT_IDLT = 4;
  localparam int LIVE_BITS = 5;
endpackage

// File: rtl/pwr_rst_sync.sv
module pwr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/pwr_ctl_reg.sv
module pwr_ctl_reg
  import pwr_mode_pkg::*;
#(
  parameter int              ADDR_W   = 8,
  parameter int              DATA_W   = 8,
  parameter logic [ADDR_W-1:0] CTL_ADDR = 8'h87
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] sfr_addr,
  input  logic              sfr_wr,
  input  logic [DATA_W-1:0] sfr_wdata,
  input  logic              run_mode,
  input  logic              wake_clr,
  output logic              enter_idle,
  output logic              enter_pdown,
  output logic              idlt,
  output logic [DATA_W-1:0] sfr_rdata
);
  localparam logic [DATA_W-1:0] LIVE_MASK = DATA_W'((1 << LIVE_BITS) - 1);

  logic [DATA_W-1:0] ctl_q, ctl_d;
  logic              addr_hit, wr_hit;

  assign addr_hit = (sfr_addr == CTL_ADDR);
  assign wr_hit   = sfr_wr && addr_hit && run_mode;

  always_comb begin
    ctl_d = ctl_q;
    if (wake_clr) begin
      ctl_d[BIT_IDL] = 1'b0;
      ctl_d[BIT_PD]  = 1'b0;
    end
    if (wr_hit) begin
      ctl_d = sfr_wdata & LIVE_MASK;
      if (sfr_wdata[BIT_PD]) ctl_d[BIT_IDL] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= '0;
    else        ctl_q <= ctl_d;
  end

  assign enter_pdown = wr_hit && sfr_wdata[BIT_PD];
  assign enter_idle  = wr_hit && sfr_wdata[BIT_IDL] && !sfr_wdata[BIT_PD];
  assign idlt        = ctl_q[BIT_IDLT];
  assign sfr_rdata   = addr_hit ? ctl_q : '0;
endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
  import pwr_mode_pkg::*;
#(
  parameter int N_EXT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enter_idle,
  input  logic             enter_pdown,
  input  logic             idlt,
  input  logic [N_EXT-1:0] ext_int_req,
  input  logic             ring_det,
  input  logic             irq_pending,
  output logic             run_mode,
  output logic             wake_clr,
  output logic             cpu_clk_en,
  output logic             periph_clk_en,
  output logic             resume_pulse,
  output logic             vector_en
);
  pwr_mode_e mode_q, mode_d;
  logic      resume_q, resume_d, vec_q, vec_d;
  logic      pd_wake, idle_wake;

  assign pd_wake   = (|ext_int_req) || ring_det;
  assign idle_wake = pd_wake || irq_pending;

  always_comb begin
    mode_d   = mode_q;
    wake_clr = 1'b0;
    resume_d = 1'b0;
    vec_d    = 1'b0;
    unique case (mode_q)
      MODE_RUN: begin
        if (enter_pdown)     mode_d = MODE_PDOWN;
        else if (enter_idle) mode_d = MODE_IDLE;
      end
      MODE_IDLE: begin
        if (idle_wake) begin
          mode_d   = MODE_RUN;
          wake_clr = 1'b1;
          resume_d = 1'b1;
          vec_d    = !idlt;
        end
      end
      MODE_PDOWN: begin
        if (pd_wake) begin
          mode_d   = MODE_RUN;
          wake_clr = 1'b1;
          resume_d = 1'b1;
          vec_d    = 1'b1;
        end
      end
      default: mode_d = MODE_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= MODE_RUN;
      resume_q <= 1'b0;
      vec_q    <= 1'b0;
    end else begin
      mode_q   <= mode_d;
      resume_q <= resume_d;
      vec_q    <= vec_d;
    end
  end

  assign run_mode      = (mode_q == MODE_RUN);
  assign cpu_clk_en    = run_mode;
  assign periph_clk_en = (mode_q != MODE_PDOWN);
  assign resume_pulse  = resume_q;
  assign vector_en     = vec_q;
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl #(
  parameter int              ADDR_W      = 8,
  parameter int              DATA_W      = 8,
  parameter int              N_EXT       = 4,
  parameter int              SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] CTL_ADDR  = 8'h87
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] sfr_addr,
  input  logic              sfr_wr,
  input  logic [DATA_W-1:0] sfr_wdata,
  output logic [DATA_W-1:0] sfr_rdata,
  input  logic [N_EXT-1:0]  ext_int_req,
  input  logic              ring_det,
  input  logic              irq_pending,
  output logic              cpu_clk_en,
  output logic              periph_clk_en,
  output logic              resume_pulse,
  output logic              vector_en
);
  logic rst_core_n, run_mode, wake_clr, enter_idle, enter_pdown, idlt;

  pwr_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  pwr_ctl_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTL_ADDR(CTL_ADDR)) u_ctl_reg (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .sfr_addr    (sfr_addr),
    .sfr_wr      (sfr_wr),
    .sfr_wdata   (sfr_wdata),
    .run_mode    (run_mode),
    .wake_clr    (wake_clr),
    .enter_idle  (enter_idle),
    .enter_pdown (enter_pdown),
    .idlt        (idlt),
    .sfr_rdata   (sfr_rdata)
  );

  pwr_mode_fsm #(.N_EXT(N_EXT)) u_mode_fsm (
    .clk           (clk),
    .rst_n         (rst_core_n),
    .enter_idle    (enter_idle),
    .enter_pdown   (enter_pdown),
    .idlt          (idlt),
    .ext_int_req   (ext_int_req),
    .ring_det      (ring_det),
    .irq_pending   (irq_pending),
    .run_mode      (run_mode),
    .wake_clr      (wake_clr),
    .cpu_clk_en    (cpu_clk_en),
    .periph_clk_en (periph_clk_en),
    .resume_pulse  (resume_pulse),
    .vector_en     (vector_en)
  );
endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
module pwr_mode_ctrl_chk #(
  parameter int              ADDR_W   = 8,
  parameter int              DATA_W   = 8,
  parameter int              N_EXT    = 4,
  parameter logic [ADDR_W-1:0] CTL_ADDR = 8'h87
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] sfr_addr,
  input logic              sfr_wr,
  input logic [1:0]        wr_sleep_bits,
  input logic [DATA_W-1:0] sfr_rdata,
  input logic [N_EXT-1:0]  ext_int_req,
  input logic              ring_det,
  input logic              cpu_clk_en,
  input logic              periph_clk_en,
  input logic              resume_pulse,
  input logic              vector_en
);
  logic ctl_write;
  assign ctl_write = sfr_wr && (sfr_addr == CTL_ADDR) && cpu_clk_en;

  p_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_rdata >> 5) == '0);

  p_idle_enter_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_write && wr_sleep_bits == 2'b01) |=> (!cpu_clk_en && periph_clk_en));

  p_pd_enter_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_write && wr_sleep_bits[1]) |=> (!cpu_clk_en && !periph_clk_en));

  p_pd_stops_cpu_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !periph_clk_en |-> !cpu_clk_en);

  p_pd_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!periph_clk_en && !(|ext_int_req) && !ring_det) |=> !periph_clk_en);

  p_resume_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
    resume_pulse |=> !resume_pulse);

  p_resume_clk_r8: assert property (@(posedge clk) disable iff (!rst_n)
    resume_pulse |-> (cpu_clk_en && periph_clk_en));

  p_vec_with_resume_r9: assert property (@(posedge clk) disable iff (!rst_n)
    vector_en |-> resume_pulse);
endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_EXT(N_EXT), .CTL_ADDR(CTL_ADDR)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .sfr_addr      (sfr_addr),
  .sfr_wr        (sfr_wr),
  .wr_sleep_bits (sfr_wdata[1:0]),
  .sfr_rdata     (sfr_rdata),
  .ext_int_req   (ext_int_req),
  .ring_det      (ring_det),
  .cpu_clk_en    (cpu_clk_en),
  .periph_clk_en (periph_clk_en),
  .resume_pulse  (resume_pulse),
  .vector_en     (vector_en)
);

// File: tb/pwr_mode_ctrl_bench.sv
module pwr_mode_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] sfr_addr, sfr_wdata, sfr_rdata;
  logic       sfr_wr, ring_det, irq_pending;
  logic [3:0] ext_int_req;
  logic       cpu_clk_en, periph_clk_en, resume_pulse, vector_en;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pwr_mode_ctrl u_pwr_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_wr(sfr_wr),
    .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .ext_int_req(ext_int_req),
    .ring_det(ring_det), .irq_pending(irq_pending), .cpu_clk_en(cpu_clk_en),
    .periph_clk_en(periph_clk_en), .resume_pulse(resume_pulse), .vector_en(vector_en)
  );

  task automatic check(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    sfr_addr = a; sfr_wdata = d; sfr_wr = 1'b1;
    @(negedge clk);
    sfr_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    sfr_addr = a;
    #1;
    d = sfr_rdata;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] r;
    rst_n = 1'b0; sfr_addr = '0; sfr_wdata = '0; sfr_wr = 1'b0;
    ext_int_req = '0; ring_det = 1'b0; irq_pending = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(8'h87, r);
    check("R1", "reg", r, 8'h00);
    check("R1", "cpu_en", {7'd0, cpu_clk_en}, 8'h01);
    check("R1", "periph_en", {7'd0, periph_clk_en}, 8'h01);
    check("R1", "resume", {7'd0, resume_pulse}, 8'h00);
    check("R1", "vector", {7'd0, vector_en}, 8'h00);

    // R2 other address: no effect, reads zero
    wr(8'h86, 8'hFF);
    rd(8'h87, r);
    check("R2", "reg after foreign write", r, 8'h00);
    rd(8'h86, r);
    check("R2", "foreign read", r, 8'h00);
    check("R2", "cpu_en after foreign write", {7'd0, cpu_clk_en}, 8'h01);

    for (int v = 0; v < 32; v++) begin
      logic [7:0] d, stored;
      logic pd, idl;
      int sel;
      d = {3'(v) ^ 3'b101, 5'(v)};
      pd = d[1];
      idl = d[0] && !d[1];
      stored = {3'b000, d[4:2], pd, idl};
      wr(8'h87, d);
      rd(8'h87, r);
      check(pd ? "R5" : "R2", "readback", r, stored);
      check(pd ? "R5" : (idl ? "R4" : "R3"), "cpu_en", {7'd0, cpu_clk_en}, {7'd0, !(pd || idl)});
      check(pd ? "R5" : (idl ? "R4" : "R3"), "periph_en", {7'd0, periph_clk_en}, {7'd0, !pd});
      if (!(pd || idl)) begin
        @(negedge clk);
        check("R3", "no resume", {7'd0, resume_pulse}, 8'h00);
      end else begin
        // R10 write while asleep is ignored
        wr(8'h87, 8'h00);
        rd(8'h87, r);
        check("R10", "reg kept while asleep", r, stored);
        check("R10", "still asleep", {7'd0, cpu_clk_en}, 8'h00);
        if (pd) begin
          irq_pending = 1'b1;
          @(negedge clk);
          irq_pending = 1'b0;
          check("R7", "irq_pending no pd wake", {7'd0, periph_clk_en}, 8'h00);
          check("R7", "no resume", {7'd0, resume_pulse}, 8'h00);
        end
        sel = pd ? (v % 5) : (v % 6);
        if (sel < 4) ext_int_req[sel] = 1'b1;
        else if (sel == 4) ring_det = 1'b1;
        else irq_pending = 1'b1;
        @(negedge clk);
        ext_int_req = '0; ring_det = 1'b0; irq_pending = 1'b0;
        check(pd ? "R7" : "R6", "wake cpu_en", {7'd0, cpu_clk_en}, 8'h01);
        check("R8", "wake periph_en", {7'd0, periph_clk_en}, 8'h01);
        check("R8", "resume high", {7'd0, resume_pulse}, 8'h01);
        check("R9", "vector", {7'd0, vector_en}, {7'd0, pd ? 1'b1 : !d[4]});
        rd(8'h87, r);
        check("R8", "bits cleared", r, {stored[7:2], 2'b00});
        @(negedge clk);
        check("R8", "resume one cycle", {7'd0, resume_pulse}, 8'h00);
        check("R9", "vector dropped", {7'd0, vector_en}, 8'h00);
      end
    end
    finish_run();
  end
endmodule